// File: doc/BRIEF.md
# Phased External Memory Write Sequencer

This block turns internal write requests into the strobe pattern an asynchronous external memory expects. A request is one address and one 16-bit data word, offered on a valid/ready handshake. The block runs the write through three phases in a fixed order: a lead phase that asserts chip-select and presents the address, an active phase that pulls the write strobe low, and a trail phase that holds data after the strobe rises. Each phase length is a programmable count of interface-clock cycles.

The interface clock leaves the block either at the timing clock rate or at half of it. Every access must begin on a rising edge of that output clock. When a request arrives half a period late, the block inserts one alignment cycle in which every control line stays inactive. A doubling bit multiplies all three phase counts by two. When the use-ready bit is set, an external ready line, brought through a two-flop synchronizer, can stretch the active phase. When the bit is clear, the ready line is ignored. The block pulses a done output as the access finishes, and only then accepts the next request. The address bus keeps its last value whenever no access is running.

Top module: `ext_write_seq`

## Requirements
- R1: After reset `cs_n`, `we_n`, `rd_n` and `rnw` are 1, `data_oe` is 0, `addr` is 0, `req_ready` is 1 and `done` is 0.
- R2: `req_ready` is 1 only while no access or alignment cycle is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `done` is high for exactly one timing-clock cycle: the first cycle after chip-select returns high.
- R3: An access runs lead, active and trail phases in that order. With `cfg_half`=0 and `cfg_double`=0 they last `cfg_lead`, `cfg_active` and `cfg_trail` timing-clock cycles. A field value of 0 counts as 1.
- R4: With `cfg_half`=1, `clk_out` toggles every timing-clock cycle and every phase lasts twice as many timing-clock cycles. The first lead cycle always has `clk_out` high. A request that arrives in the other half period waits one alignment cycle, during which all strobes stay inactive.
- R5: With `cfg_double`=1, each programmed phase count is multiplied by two.
- R6: `cs_n` and `rnw` go low together at the start of lead and return high together at the end of trail. `addr` takes the request address at the start of lead.
- R7: While `cs_n` is high, `addr` keeps the last address driven.
- R8: `we_n` is low exactly during the active phase and never while `cs_n` is high.
- R9: `data_oe` is 0 in lead, 1 from the start of active through trail, and 1 for exactly one more cycle after `rnw` returns high. While `data_oe` is 1, `data_out` equals the request data.
- R10: `rd_n` stays 1 at all times.
- R11: With `cfg_use_ready`=0, `ext_ready` has no effect on the active phase length.
- R12: With `cfg_use_ready`=1, the active phase extends past its programmed count for as long as the synchronized `ext_ready` is 0. `ext_ready` passes through two flops before it is used, so in full-rate mode a rise seen during active cycle M (M at or above the count) ends the active phase after M+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lead | input | 4 | Lead phase count |
| cfg_active | input | 4 | Active phase count |
| cfg_trail | input | 4 | Trail phase count |
| cfg_double | input | 1 | Multiply all phase counts by two |
| cfg_half | input | 1 | Interface clock at half the timing clock |
| cfg_use_ready | input | 1 | Let ext_ready stretch the active phase |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 19 | Request address |
| req_data | input | 16 | Request write data |
| done | output | 1 | One-cycle pulse when an access ends |
| clk_out | output | 1 | Interface clock output |
| cs_n | output | 1 | Zone chip-select, active low |
| addr | output | 19 | External address bus |
| we_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, held inactive |
| rnw | output | 1 | Direction line, low for a write |
| data_out | output | 16 | Write data bus value |
| data_oe | output | 1 | Data bus output enable |
| ext_ready | input | 1 | Asynchronous external ready |

## Verification
The bench issues requests in half-rate mode at varying offsets, so some land on the wrong half period. A design without alignment would start lead while `clk_out` is low, and a design that aligned wrongly would stretch or shorten the lead phase. Zero-valued fields, the doubling bit and half-rate mode are checked against phase lengths measured at the pins. A counter that loaded the raw value or dropped a multiplier shows up as a wrong count. In the ready tests, `ext_ready` is held low with use-ready both clear and set, and it rises late in the active phase. If the ignore bit leaks, the active phase runs long. A missing or extra synchronizer stage moves the end of the active phase by a cycle. Between accesses the bench watches for address drift and for a data enable that is held too long or dropped too early.

// File: rtl/ewseq_pkg.sv
package ewseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ALIGN  = 3'd1,
        ST_LEAD   = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_TRAIL  = 3'd4
    } ph_state_e;

    // Phase counts as presented to the sequencer.
    typedef struct packed {
        logic [3:0] lead;
        logic [3:0] active;
        logic [3:0] trail;
        logic       dbl;
        logic       use_rdy;
    } ph_cfg_t;

    // Number of interface cycles a field asks for, minus one (counter load).
    function automatic logic [4:0] load_val(input logic [3:0] fld, input logic dbl);
        logic [4:0] n;
        n = (fld == 4'd0) ? 5'd1 : {1'b0, fld};
        if (dbl) n = n << 1;
        return n - 5'd1;
    endfunction

    function automatic logic in_access(input ph_state_e s);
        return (s == ST_LEAD) || (s == ST_ACTIVE) || (s == ST_TRAIL);
    endfunction

endpackage

// File: rtl/ewseq_clkdiv.sv
module ewseq_clkdiv (
    input  logic clk,
    input  logic rst,
    input  logic half,
    output logic tick,
    output logic clk_out
);
    logic div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= 1'b0;
        else     div_q <= ~div_q;
    end

    // An interface cycle begins at an edge where the divider is low;
    // after that edge the divided clock is high (its rising edge).
    assign tick    = ~half | ~div_q;
    assign clk_out = half ? div_q : clk;
endmodule

// File: rtl/ewseq_sync.sv
module ewseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ewseq_fsm.sv
module ewseq_fsm
    import ewseq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  ph_cfg_t   cfg,
    input  logic      tick,
    input  logic      rdy,
    input  logic      req_valid,
    output ph_state_e state,
    output ph_state_e state_nxt,
    output logic      accept,
    output logic      start,
    output logic      finish
);
    ph_state_e  st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ld_lead, ld_act, ld_trail;
    logic hold_active;

    assign ld_lead  = CNT_W'(load_val(cfg.lead,   cfg.dbl));
    assign ld_act   = CNT_W'(load_val(cfg.active, cfg.dbl));
    assign ld_trail = CNT_W'(load_val(cfg.trail,  cfg.dbl));
    assign hold_active = cfg.use_rdy & ~rdy;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        accept = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (tick) begin
                        st_d  = ST_LEAD;
                        cnt_d = ld_lead;
                    end else begin
                        st_d = ST_ALIGN;
                    end
                end
            end
            ST_ALIGN: begin
                if (tick) begin
                    st_d  = ST_LEAD;
                    cnt_d = ld_lead;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    if (cnt_q == '0) begin
                        st_d  = ST_ACTIVE;
                        cnt_d = ld_act;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_ACTIVE: begin
                if (tick) begin
                    if (cnt_q == '0) begin
                        if (!hold_active) begin
                            st_d  = ST_TRAIL;
                            cnt_d = ld_trail;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (cnt_q == '0) st_d = ST_IDLE;
                    else             cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state     = st_q;
    assign state_nxt = st_d;
    assign start     = (st_d == ST_LEAD) && (st_q != ST_LEAD);
    assign finish    = (st_q == ST_TRAIL) && (st_d == ST_IDLE);
endmodule

// File: rtl/ext_write_seq.sv
module ext_write_seq
    import ewseq_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 16,
    parameter int FIELD_W  = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FIELD_W-1:0] cfg_lead,
    input  logic [FIELD_W-1:0] cfg_active,
    input  logic [FIELD_W-1:0] cfg_trail,
    input  logic              cfg_double,
    input  logic              cfg_half,
    input  logic              cfg_use_ready,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic              clk_out,
    output logic              cs_n,
    output logic [ADDR_W-1:0] addr,
    output logic              we_n,
    output logic              rd_n,
    output logic              rnw,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              ext_ready
);
    localparam int CNT_W = FIELD_W + 1;

    ph_cfg_t   cfg;
    ph_state_e state, state_nxt;
    logic tick, rdy_s, accept, start, finish;
    logic [ADDR_W-1:0] pend_addr_q, addr_q;
    logic [DATA_W-1:0] data_q;
    logic oe_q, done_q;

    assign cfg.lead    = cfg_lead;
    assign cfg.active  = cfg_active;
    assign cfg.trail   = cfg_trail;
    assign cfg.dbl     = cfg_double;
    assign cfg.use_rdy = cfg_use_ready;

    ewseq_clkdiv i_div (
        .clk(clk), .rst(rst), .half(cfg_half), .tick(tick), .clk_out(clk_out)
    );

    ewseq_sync #(.STAGES(SYNC_LEN)) i_sync (
        .clk(clk), .rst(rst), .d(ext_ready), .q(rdy_s)
    );

    ewseq_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk(clk), .rst(rst), .cfg(cfg), .tick(tick), .rdy(rdy_s),
        .req_valid(req_valid), .state(state), .state_nxt(state_nxt),
        .accept(accept), .start(start), .finish(finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_addr_q <= '0;
            addr_q      <= '0;
            data_q      <= '0;
            oe_q        <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            if (accept) begin
                pend_addr_q <= req_addr;
                data_q      <= req_data;
            end
            if (start)
                addr_q <= (state == ST_IDLE) ? req_addr : pend_addr_q;
            oe_q   <= (state_nxt == ST_ACTIVE) || (state_nxt == ST_TRAIL) || finish;
            done_q <= finish;
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign cs_n      = ~in_access(state);
    assign rnw       = ~in_access(state);
    assign we_n      = ~(state == ST_ACTIVE);
    assign rd_n      = 1'b1;
    assign addr      = addr_q;
    assign data_out  = data_q;
    assign data_oe   = oe_q;
    assign done      = done_q;
endmodule

// File: rtl/ewseq_chk.sv
module ewseq_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_half,
    input logic              req_ready,
    input logic              done,
    input logic              clk_out,
    input logic              cs_n,
    input logic [ADDR_W-1:0] addr,
    input logic              we_n,
    input logic              rd_n,
    input logic              rnw,
    input logic              data_oe
);
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> !req_ready);                                   // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                         // R2
    AST_LEAD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (cfg_half && $fell(cs_n)) |-> clk_out);                  // R4
    AST_RNW_WITH_CS: assert property (@(posedge clk) disable iff (rst)
        rnw == cs_n);                                            // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> $stable(addr));                // R7
    AST_WE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !cs_n);                                        // R8
    AST_OE_COVERS_WE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> data_oe);                                      // R9
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(rnw) |-> data_oe ##1 !data_oe);                    // R9
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        rd_n);                                                   // R10
endmodule

bind ext_write_seq ewseq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .cfg_half(cfg_half), .req_ready(req_ready),
    .done(done), .clk_out(clk_out), .cs_n(cs_n), .addr(addr), .we_n(we_n),
    .rd_n(rd_n), .rnw(rnw), .data_oe(data_oe)
);

// File: tb/test_ext_write_seq.sv
`timescale 1ns/1ps
module test_ext_write_seq;
    logic clk = 1'b0, rst = 1'b1;
    logic [3:0] cfg_lead = 4'd1, cfg_active = 4'd1, cfg_trail = 4'd1;
    logic cfg_double = 1'b0, cfg_half = 1'b0, cfg_use_ready = 1'b0;
    logic req_valid = 1'b0, req_ready, done, clk_out, cs_n, we_n, rd_n, rnw, data_oe;
    logic [18:0] req_addr = '0, addr;
    logic [15:0] req_data = '0, data_out;
    logic ext_ready = 1'b1;

    always #2 clk = ~clk;

    ext_write_seq i_ext_write_seq (
        .clk(clk), .rst(rst), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
        .cfg_trail(cfg_trail), .cfg_double(cfg_double), .cfg_half(cfg_half),
        .cfg_use_ready(cfg_use_ready), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .done(done), .clk_out(clk_out),
        .cs_n(cs_n), .addr(addr), .we_n(we_n), .rd_n(rd_n), .rnw(rnw),
        .data_out(data_out), .data_oe(data_oe), .ext_ready(ext_ready)
    );

    typedef struct {
        logic [18:0] a;
        logic [15:0] d;
        int l, ac, t;
        bit half;
    } exp_t;
    exp_t sb[$];

    int checks = 0, errors = 0;
    int rise_at = 0, act_seen = 0;
    bit mon_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int plen(input int f, input bit dbl, input bit half);
        int n;
        n = (f == 0) ? 1 : f;
        if (dbl) n = n * 2;
        if (half) n = n * 2;
        return n;
    endfunction

    // Driver: pushes the expected access, then offers the request.
    task automatic write_req(input logic [18:0] a, input logic [15:0] d,
                             input int gap, input int act_override);
        exp_t e;
        for (int i = 0; i < gap; i++) @(negedge clk);
        e.a = a; e.d = d; e.half = cfg_half;
        e.l  = plen(cfg_lead, cfg_double, cfg_half);
        e.ac = (act_override > 0) ? act_override : plen(cfg_active, cfg_double, cfg_half);
        e.t  = plen(cfg_trail, cfg_double, cfg_half);
        sb.push_back(e);
        req_addr = a; req_data = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Raises ext_ready during the rise_at-th active sample.
    always @(negedge clk) begin
        if (!we_n) begin
            act_seen = act_seen + 1;
            if (rise_at > 0 && act_seen == rise_at) ext_ready = 1'b1;
        end else begin
            act_seen = 0;
        end
    end

    // Monitor: measures each access at the pins and compares with the queue.
    bit in_acc = 1'b0, prev_cs = 1'b1;
    int ph = 0, nl = 0, na = 0, nt = 0, post = 0;
    logic [18:0] last_addr = '0;
    logic [15:0] exp_d = '0;
    always @(negedge clk) begin
        if (mon_on) begin
            chk(rd_n == 1'b1, "R10 rd_n", rd_n, 1);
            chk(rnw == cs_n, "R6 rnw follows cs_n", rnw, cs_n);
            if (cs_n) begin
                chk(addr == last_addr, "R7 addr hold", addr, last_addr);
                chk(we_n == 1'b1, "R8 we_n idle", we_n, 1);
                if (in_acc) begin
                    exp_t e;
                    in_acc = 1'b0;
                    chk(data_oe == 1'b1, "R9 oe one cycle after rnw", data_oe, 1);
                    chk(done == 1'b1, "R2 done after access", done, 1);
                    if (sb.size() == 0) chk(1'b0, "R2 unexpected access", 0, 1);
                    else begin
                        e = sb.pop_front();
                        chk(nl == e.l,  "R3 lead length",   nl, e.l);
                        chk(na == e.ac, "R3 active length", na, e.ac);
                        chk(nt == e.t,  "R3 trail length",  nt, e.t);
                        chk(last_addr == e.a, "R6 address", last_addr, e.a);
                    end
                end else begin
                    chk(data_oe == 1'b0, "R9 oe released", data_oe, 0);
                    chk(done == 1'b0, "R2 done single pulse", done, 0);
                end
            end else begin
                chk(req_ready == 1'b0, "R2 ready during access", req_ready, 0);
                chk(done == 1'b0, "R2 done inside access", done, 0);
                if (!in_acc) begin
                    in_acc = 1'b1; ph = 0; nl = 0; na = 0; nt = 0;
                    last_addr = addr;
                    if (sb.size() > 0) begin
                        exp_d = sb[0].d;
                        if (sb[0].half) chk(clk_out == 1'b1, "R4 lead on rising edge", clk_out, 1);
                    end
                end
                if (ph == 0 && !we_n) ph = 1;
                if (ph == 1 && we_n) ph = 2;
                if (ph == 0) begin
                    nl++;
                    chk(data_oe == 1'b0, "R9 oe low in lead", data_oe, 0);
                end else begin
                    if (ph == 1) na++; else nt++;
                    chk(data_oe == 1'b1, "R9 oe in active/trail", data_oe, 1);
                    chk(data_out == exp_d, "R9 data value", data_out, exp_d);
                end
            end
            prev_cs = cs_n;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(cs_n == 1 && we_n == 1 && rd_n == 1 && rnw == 1, "R1 strobes idle", {cs_n, we_n, rd_n, rnw}, 4'hF);
        chk(data_oe == 0 && done == 0, "R1 oe/done low", {data_oe, done}, 0);
        chk(addr == 0 && req_ready == 1, "R1 addr/ready", {addr, req_ready}, 1);
        mon_on = 1'b1;

        // R3: basic lengths, full rate
        cfg_lead = 4'd2; cfg_active = 4'd3; cfg_trail = 4'd1;
        write_req(19'h12345, 16'hA5C3, 1, 0);
        // R3: zero fields count as one
        cfg_lead = 4'd0; cfg_active = 4'd0; cfg_trail = 4'd0;
        write_req(19'h00001, 16'h0F0F, 0, 0);
        // R5: doubling
        cfg_lead = 4'd1; cfg_active = 4'd2; cfg_trail = 4'd3; cfg_double = 1'b1;
        write_req(19'h7FFFF, 16'hFFFF, 2, 0);
        cfg_double = 1'b0;
        // R4: half rate with varied offsets (both alignments)
        cfg_half = 1'b1; cfg_lead = 4'd1; cfg_active = 4'd2; cfg_trail = 4'd1;
        for (int g = 0; g < 4; g++)
            write_req(19'h00100 + 19'(g), 16'h1000 + 16'(g), g, 0);
        cfg_double = 1'b1;
        write_req(19'h2AAAA, 16'h5555, 3, 0);
        cfg_double = 1'b0; cfg_half = 1'b0;
        repeat (3) @(negedge clk);

        // R11: ready ignored when use-ready is clear
        cfg_lead = 4'd1; cfg_active = 4'd2; cfg_trail = 4'd2;
        cfg_use_ready = 1'b0; ext_ready = 1'b0; rise_at = 0;
        write_req(19'h03333, 16'hBEEF, 1, 0);
        // R12: ready high all along, no stretch
        cfg_use_ready = 1'b1; ext_ready = 1'b1;
        repeat (3) @(negedge clk);
        write_req(19'h04444, 16'hCAFE, 0, 0);
        // R12: ready low, rises in active sample 5 -> active lasts 7
        ext_ready = 1'b0;
        repeat (3) @(negedge clk);
        rise_at = 5;
        write_req(19'h05555, 16'h1234, 0, 7);
        rise_at = 0; ext_ready = 1'b1; cfg_use_ready = 1'b0;

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R2 all accesses completed", sb.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule